// File: doc/BRIEF.md
# Configurable UART Transmit Framer

This block turns parallel characters into an asynchronous serial stream on a single output line. A 7-bit format byte selects the character length (5 to 8 bits), the number of stop bits (1, 1.5 or 2), whether a parity bit is added and how it is formed (odd, even, forced high, forced low), and a break bit that pulls the line low. Bit timing comes from a 16-bit divisor: an internal enable pulses once every `divisor` clock cycles, and each serial bit lasts 16 of those pulses.

Characters arrive over a valid/ready handshake into a one-entry holding register. When the serializer finishes a frame, the held character moves into it one clock later. Two flags report progress. `thr_empty` shows that a new character can be written. `tx_empty` shows that both the holding register and the serializer are idle. The format fields are captured when each frame starts, so software may change them while a frame is in flight.

Top module: `uart_tx_framer`

## Requirements
- R1: After reset, `txd` is 1 and `thr_empty`, `tx_empty` and `tx_ready` are all 1. When no frame is in progress and break is off, `txd` stays 1.
- R2: `line_ctrl[1:0]` sets the data length: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. Data bits go out least significant first, and only the low bits of `tx_data` are sent.
- R3: A frame begins with a start bit at 0. Every start, data and parity bit lasts exactly 16×D clock cycles, where D is `divisor`, or 1 when `divisor` is 0. The baud phase restarts when a frame starts.
- R4: With `line_ctrl[2]` = 0 the stop period is 1 bit (16 ticks) at 1. With `line_ctrl[2]` = 1 it is 24 ticks for 5-bit words and 32 ticks for 6-, 7- and 8-bit words.
- R5: With `line_ctrl[3]` = 1 and `line_ctrl[5]` = 0, a parity bit follows the data. `line_ctrl[4]` = 0 makes it odd (data plus parity hold an odd count of ones) and 1 makes it even. With `line_ctrl[3]` = 0 no parity bit is sent.
- R6: With `line_ctrl[3]` and `line_ctrl[5]` both 1, the parity bit is the inverse of `line_ctrl[4]`.
- R7: While `line_ctrl[6]` is 1, `txd` is 0 whether or not a frame is running. Clearing the bit gives the line back to the frame or to idle at once.
- R8: `tx_ready` and `thr_empty` are 1 exactly when the holding register is free. A write lowers `thr_empty` on the next cycle. `tx_empty` is 1 only when the holding register is free and no frame is in progress.
- R9: A character waiting in the holding register begins its start bit one clock cycle after the previous frame's stop period ends.
- R10: The format fields `line_ctrl[5:0]` are captured when a frame starts. Changing them during the frame does not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_ctrl | input | 7 | Format byte: length [1:0], stop [2], parity enable [3], parity sense [4], forced parity [5], break [6] |
| divisor | input | 16 | Clock cycles per baud tick; 0 is treated as 1 |
| tx_data | input | 8 | Character to send |
| tx_valid | input | 1 | `tx_data` is offered |
| tx_ready | output | 1 | Holding register can take a character |
| txd | output | 1 | Serial output line |
| thr_empty | output | 1 | Holding register is empty |
| tx_empty | output | 1 | Holding register and serializer both empty |

## Verification
The hardest case to reach from the ports is the exact one-cycle hand-off, where a held character starts right after a stop period. The stop length changes with both the data length and the stop-bit field, so the hand-off follows a stop period of 16, 24 or 32 ticks. The stimulus reaches it by writing a second and third character while the first frame is still on the line. The monitor then measures the distance between each stop end and the next falling edge. A format change made in the middle of a frame is also hard to see at the ports. The bench makes that change after the start bit has been observed and decodes the frame against the format that was captured when the frame started.

// File: rtl/uart_tx_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the UART transmit framer.
// Assumes a fixed oversampling of 16 baud ticks per serial bit.
package uart_tx_pkg;

    localparam int OS_TICKS = 16;
    localparam int STOP_W   = $clog2(2 * OS_TICKS + 1);

    typedef enum logic [2:0] {
        TX_IDLE,
        TX_START,
        TX_DATA,
        TX_PARITY,
        TX_STOP
    } tx_state_e;

    typedef struct packed {
        logic [3:0]        data_bits;
        logic              par_en;
        logic              par_stick;
        logic              par_even;
        logic [STOP_W-1:0] stop_ticks;
    } frame_cfg_t;

endpackage

// File: rtl/tx_baud_gen.sv
`timescale 1ns/1ps
// Baud enable generator: pulses tick once every divisor cycles.
// Assumes divisor 0 behaves like 1; restart realigns the phase to a frame start.
module tx_baud_gen #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] divisor,
    input  logic             restart,
    output logic             tick
);

    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] limit;

    // Terminal count, clamping a zero divisor to one cycle per tick
    always_comb limit = (divisor == '0) ? '0 : divisor - 1'b1;

    // Tick whenever the count has reached the limit (>= covers a divisor shrink)
    always_comb tick = (cnt >= limit);

    // Free-running cycle counter with synchronous restart
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (restart || tick)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/tx_frame_decode.sv
`timescale 1ns/1ps
// Decodes the format field of the control byte into frame parameters.
// Purely combinational; the shift engine latches the result at frame start.
module tx_frame_decode
    import uart_tx_pkg::*;
(
    input  logic [5:0] fmt,
    output frame_cfg_t cfg
);

    localparam logic [STOP_W-1:0] STOP_ONE  = STOP_W'(OS_TICKS);
    localparam logic [STOP_W-1:0] STOP_HALF = STOP_W'(OS_TICKS + OS_TICKS / 2);
    localparam logic [STOP_W-1:0] STOP_TWO  = STOP_W'(2 * OS_TICKS);

    // Map length, stop and parity fields onto the frame descriptor
    always_comb begin
        cfg.data_bits = 4'd5 + {2'b00, fmt[1:0]};
        cfg.par_en    = fmt[3];
        cfg.par_even  = fmt[4];
        cfg.par_stick = fmt[5];
        if (!fmt[2])
            cfg.stop_ticks = STOP_ONE;
        else if (fmt[1:0] == 2'b00)
            cfg.stop_ticks = STOP_HALF;
        else
            cfg.stop_ticks = STOP_TWO;
    end

endmodule

// File: rtl/tx_hold_reg.sv
`timescale 1ns/1ps
// One-entry holding register between the handshake and the shift engine.
// Assumes take is asserted only while full is high.
module tx_hold_reg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_ready,
    input  logic              take,
    output logic              full,
    output logic [DATA_W-1:0] data
);

    // Ready whenever the single slot is free
    always_comb wr_ready = !full;

    // Capture on an accepted write, release when the engine takes it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full <= 1'b0;
            data <= '0;
        end else begin
            if (take)
                full <= 1'b0;
            if (wr_valid && !full) begin
                full <= 1'b1;
                data <= wr_data;
            end
        end
    end

endmodule

// File: rtl/tx_shift_engine.sv
`timescale 1ns/1ps
// Frame sequencer: start, data (LSB first), optional parity, stop.
// Assumes cfg_in is stable in the load cycle; it is latched for the whole frame.
module tx_shift_engine
    import uart_tx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              load_req,
    input  logic [DATA_W-1:0] load_data,
    input  frame_cfg_t        cfg_in,
    output logic              load_ack,
    output logic              busy,
    output logic              line_bit
);

    localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

    tx_state_e         state;
    frame_cfg_t        cfg_q;
    logic [STOP_W-1:0] tcnt;
    logic [STOP_W-1:0] bit_len;
    logic [IDX_W-1:0]  bidx;
    logic [DATA_W-1:0] sreg;
    logic              par_bit;
    logic              bit_done;
    logic              last_data;

    // Parity over the active data bits, or the forced value
    function automatic logic calc_parity(input logic [DATA_W-1:0] d, input frame_cfg_t c);
        logic x;
        x = 1'b0;
        for (int i = 0; i < DATA_W; i++)
            if (i < int'(c.data_bits))
                x = x ^ d[i];
        if (c.par_stick)
            return !c.par_even;
        return c.par_even ? x : !x;
    endfunction

    // Length of the current bit in baud ticks
    always_comb bit_len = (state == TX_STOP) ? cfg_q.stop_ticks : STOP_W'(OS_TICKS);

    // Last tick of the current bit, last data bit of the word
    always_comb begin
        bit_done  = tick && (tcnt == bit_len - 1'b1);
        last_data = (int'(bidx) == int'(cfg_q.data_bits) - 1);
    end

    // Hand-shake with the holding register and activity flag
    always_comb begin
        load_ack = (state == TX_IDLE) && load_req;
        busy     = (state != TX_IDLE);
    end

    // Serial level for the current state
    always_comb begin
        unique case (state)
            TX_START:  line_bit = 1'b0;
            TX_DATA:   line_bit = sreg[0];
            TX_PARITY: line_bit = par_bit;
            default:   line_bit = 1'b1;
        endcase
    end

    // Frame state machine with tick counter and shifter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= TX_IDLE;
            cfg_q   <= '0;
            tcnt    <= '0;
            bidx    <= '0;
            sreg    <= '0;
            par_bit <= 1'b0;
        end else if (state == TX_IDLE) begin
            if (load_req) begin
                state   <= TX_START;
                cfg_q   <= cfg_in;
                tcnt    <= '0;
                bidx    <= '0;
                sreg    <= load_data;
                par_bit <= calc_parity(load_data, cfg_in);
            end
        end else if (tick) begin
            if (!bit_done) begin
                tcnt <= tcnt + 1'b1;
            end else begin
                tcnt <= '0;
                unique case (state)
                    TX_START: state <= TX_DATA;
                    TX_DATA: begin
                        if (last_data)
                            state <= cfg_q.par_en ? TX_PARITY : TX_STOP;
                        else begin
                            bidx <= bidx + 1'b1;
                            sreg <= sreg >> 1;
                        end
                    end
                    TX_PARITY: state <= TX_STOP;
                    default:   state <= TX_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/uart_tx_framer.sv
`timescale 1ns/1ps
// UART transmit framer top: holding register, baud generator, format
// decoder and shift engine. Break forces the line low regardless of frames.
module uart_tx_framer
    import uart_tx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [6:0]        line_ctrl,
    input  logic [DIV_W-1:0]  divisor,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    output logic              txd,
    output logic              thr_empty,
    output logic              tx_empty
);

    localparam int BRK_BIT = 6;

    logic              hold_full;
    logic [DATA_W-1:0] hold_data;
    logic              load_ack;
    logic              busy;
    logic              line_bit;
    logic              tick;
    frame_cfg_t        cfg;

    tx_hold_reg #(.DATA_W(DATA_W)) i_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_valid (tx_valid),
        .wr_data  (tx_data),
        .wr_ready (tx_ready),
        .take     (load_ack),
        .full     (hold_full),
        .data     (hold_data)
    );

    tx_baud_gen #(.DIV_W(DIV_W)) i_baud (
        .clk     (clk),
        .rst_n   (rst_n),
        .divisor (divisor),
        .restart (load_ack),
        .tick    (tick)
    );

    tx_frame_decode i_decode (
        .fmt (line_ctrl[5:0]),
        .cfg (cfg)
    );

    tx_shift_engine #(.DATA_W(DATA_W)) i_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .load_req  (hold_full),
        .load_data (hold_data),
        .cfg_in    (cfg),
        .load_ack  (load_ack),
        .busy      (busy),
        .line_bit  (line_bit)
    );

    // Output line with break override, and status flags
    always_comb begin
        txd       = line_ctrl[BRK_BIT] ? 1'b0 : line_bit;
        thr_empty = !hold_full;
        tx_empty  = !hold_full && !busy;
    end

endmodule

// File: rtl/uart_tx_framer_chk.sv
`timescale 1ns/1ps
// Property checker for uart_tx_framer, attached by bind.
// Observes ports only.
module uart_tx_framer_chk (
    input logic clk,
    input logic rst_n,
    input logic brk,
    input logic tx_valid,
    input logic tx_ready,
    input logic txd,
    input logic thr_empty,
    input logic tx_empty
);

    assert_break_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        brk |-> !txd);

    assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_empty && !brk) |-> txd);

    assert_empty_implies_free_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty |-> thr_empty);

    assert_write_fills_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready) |=> !thr_empty);

    assert_load_starts_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(thr_empty) && !brk) |-> !txd);

endmodule

bind uart_tx_framer uart_tx_framer_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .brk       (line_ctrl[6]),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready),
    .txd       (txd),
    .thr_empty (thr_empty),
    .tx_empty  (tx_empty)
);

// File: tb/test_uart_tx_framer.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver queues expected frames, the monitor decodes txd.
module test_uart_tx_framer;

    typedef struct {
        logic [11:0] bits;
        int          nb;
        int          nd;
        int          stopc;
        int          dv;
        bit          b2b;
        bit          r10;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  line_ctrl = 7'h03;
    logic [15:0] divisor = 16'd1;
    logic [7:0]  tx_data = 8'h00;
    logic        tx_valid = 1'b0;
    logic        tx_ready, txd, thr_empty, tx_empty;

    int   n_checks = 0;
    int   n_fail = 0;
    int   cyc = 0;
    int   prev_end = 0;
    bit   mon_en = 1'b1;
    bit   done = 1'b0;
    exp_t q[$];

    uart_tx_framer i_uart_tx_framer (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_ctrl (line_ctrl),
        .divisor   (divisor),
        .tx_data   (tx_data),
        .tx_valid  (tx_valid),
        .tx_ready  (tx_ready),
        .txd       (txd),
        .thr_empty (thr_empty),
        .tx_empty  (tx_empty)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    // Expected frame from the format byte (R2 R4 R5 R6)
    function automatic exp_t mk(input logic [6:0] lc, input logic [7:0] d, input int dv,
                                input bit b2b, input bit r10);
        exp_t e;
        bit   x;
        e.bits = '0;
        e.nd = 5 + int'(lc[1:0]);
        for (int i = 0; i < e.nd; i++) e.bits[1 + i] = d[i];
        e.nb = 1 + e.nd;
        if (lc[3]) begin
            x = 1'b0;
            for (int i = 0; i < e.nd; i++) x ^= d[i];
            e.bits[e.nb] = lc[5] ? !lc[4] : (lc[4] ? x : !x);
            e.nb++;
        end
        e.stopc = !lc[2] ? 16 : (e.nd == 5 ? 24 : 32);
        e.dv = (dv == 0) ? 1 : dv;
        e.b2b = b2b;
        e.r10 = r10;
        return e;
    endfunction

    // Driver: offer a byte, queue its expected frame at acceptance
    task automatic send(input logic [7:0] d, input bit push, input bit r10);
        @(negedge clk);
        tx_data = d;
        tx_valid = 1'b1;
        while (!tx_ready) @(negedge clk);
        if (push) q.push_back(mk(line_ctrl, d, int'(divisor), !tx_empty, r10));
        @(negedge clk);
        tx_valid = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (!tx_empty) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    // Monitor: decode each frame at bit centres and compare with the queue
    initial begin
        forever begin
            @(negedge clk);
            if (mon_en && rst_n && txd == 1'b0) begin
                if (q.size() == 0) begin
                    check(1'b0, "R3 unexpected start bit", 0, 1);
                    while (txd == 1'b0) @(negedge clk);
                end else begin
                    exp_t e;
                    int   t0, bl, off, tgt;
                    string tg;
                    e = q.pop_front();
                    t0 = cyc;
                    bl = 16 * e.dv;
                    off = 0;
                    tg = e.r10 ? " (R10)" : "";
                    if (e.b2b) check(t0 == prev_end + 1, "R9 hand-off gap", t0 - prev_end, 1);
                    for (int k = 0; k < e.nb; k++) begin
                        tgt = k * bl + bl / 2;
                        repeat (tgt - off) @(negedge clk);
                        off = tgt;
                        if (k == 0)
                            check(txd == e.bits[k], {"R3 start bit", tg}, int'(txd), int'(e.bits[k]));
                        else if (k <= e.nd)
                            check(txd == e.bits[k], $sformatf("R2 data bit %0d%s", k - 1, tg),
                                  int'(txd), int'(e.bits[k]));
                        else
                            check(txd == e.bits[k], {"R5/R6 parity bit", tg}, int'(txd), int'(e.bits[k]));
                    end
                    tgt = e.nb * bl;
                    repeat (tgt - off) @(negedge clk);
                    off = tgt;
                    check(txd == 1'b1, {"R4 stop start", tg}, int'(txd), 1);
                    tgt = e.nb * bl + e.stopc * e.dv - 1;
                    repeat (tgt - off) @(negedge clk);
                    check(txd == 1'b1, {"R4 stop end", tg}, int'(txd), 1);
                    prev_end = t0 + tgt + 1;
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog (all requirements): actual hung expected done");
        finish_run();
    end

    // Stimulus
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(txd == 1'b1, "R1 txd idle", int'(txd), 1);
        check(thr_empty == 1'b1, "R1 thr_empty", int'(thr_empty), 1);
        check(tx_empty == 1'b1, "R1 tx_empty", int'(tx_empty), 1);
        check(tx_ready == 1'b1, "R1 tx_ready", int'(tx_ready), 1);

        // 8N1, and R8 flags mid-frame and after
        divisor = 16'd1; line_ctrl = 7'h03;
        send(8'hA5, 1, 0);
        repeat (20) @(negedge clk);
        check(thr_empty == 1'b1, "R8 thr_empty during frame", int'(thr_empty), 1);
        check(tx_empty == 1'b0, "R8 tx_empty during frame", int'(tx_empty), 0);
        wait_idle();
        check(tx_empty == 1'b1 && thr_empty == 1'b1, "R8 flags after frame", int'(tx_empty), 1);
        check(txd == 1'b1, "R1 idle after frame", int'(txd), 1);

        // R2 5-bit, one stop, no parity
        line_ctrl = 7'h00; send(8'hF3, 1, 0); wait_idle();
        // R5 6-bit even parity
        line_ctrl = 7'h19; send(8'h2D, 1, 0); wait_idle();
        // R5 7-bit odd parity, R4 two stops
        line_ctrl = 7'h0E; send(8'h55, 1, 0); wait_idle();
        // R6 mark parity on 5-bit, R4 1.5 stops
        line_ctrl = 7'h2C; send(8'h0A, 1, 0); wait_idle();
        // R6 space parity on 8-bit, two stops
        line_ctrl = 7'h3F; send(8'hFF, 1, 0); wait_idle();
        // R3 divisor 0 acts as 1, 8-bit even
        divisor = 16'd0; line_ctrl = 7'h1B; send(8'h81, 1, 0); wait_idle();
        // R3 divisor 3, 7-bit even
        divisor = 16'd3; line_ctrl = 7'h1A; send(8'h3A, 1, 0); wait_idle();

        // R9 back-to-back with 1.5 stops then 2 stops
        divisor = 16'd1; line_ctrl = 7'h2C;
        send(8'h15, 1, 0);
        send(8'h0E, 1, 0);
        check(thr_empty == 1'b0 && tx_ready == 1'b0, "R8 holding occupied", int'(thr_empty), 0);
        send(8'h11, 1, 0);
        wait_idle();
        line_ctrl = 7'h07;
        send(8'h00, 1, 0); send(8'hFF, 1, 0); send(8'h5A, 1, 0);
        wait_idle();

        // R10 format change during a frame
        line_ctrl = 7'h03;
        send(8'hC3, 1, 1);
        repeat (30) @(negedge clk);
        line_ctrl = 7'h3C;
        wait_idle();
        line_ctrl = 7'h03;

        // R7 break while idle
        mon_en = 1'b0;
        line_ctrl = 7'h43;
        @(negedge clk);
        check(txd == 1'b0, "R7 break idle", int'(txd), 0);
        repeat (5) @(negedge clk);
        check(txd == 1'b0 && tx_empty == 1'b1, "R7 break held, no frame", int'(txd), 0);
        line_ctrl = 7'h03;
        @(negedge clk);
        check(txd == 1'b1, "R7 release to idle", int'(txd), 1);

        // R7 break during a frame of ones
        send(8'hFF, 0, 0);
        repeat (40) @(negedge clk);
        check(txd == 1'b1, "R7 frame bit before break", int'(txd), 1);
        line_ctrl = 7'h43;
        @(negedge clk);
        check(txd == 1'b0, "R7 break over frame", int'(txd), 0);
        line_ctrl = 7'h03;
        @(negedge clk);
        check(txd == 1'b1, "R7 frame resumes", int'(txd), 1);
        wait_idle();
        mon_en = 1'b1;

        check(q.size() == 0, "R3 all frames observed", q.size(), 0);
        finish_run();
    end

endmodule